// File: doc/BRIEF.md
# Arm-then-fire level trigger

This block watches a stream of unsigned samples coming out of a scope filter and raises a trigger event when the signal makes a qualified crossing. It does not compare against a single threshold. It uses two programmable levels. The signal must first pass one level, which puts the detector in an armed state. It must then pass the other level, which fires the trigger. The gap between the two levels acts as hysteresis, so noise around one threshold cannot produce a burst of triggers.

A slope select chooses between a rising trigger and a falling trigger. A rising trigger arms low and fires high. A falling trigger arms high and fires low. Firing produces a one-cycle pulse and returns the detector to the disarmed state. It also sets a sticky flag, which software polls and clears. If the levels or the slope change, the detector drops back to disarmed, so a half-finished sequence cannot complete against a new configuration.

Top module: `lvl_trig`

## Requirements
- R1: While reset is asserted and after it is released, trig_pulse, armed and triggered are all low until a qualifying sample arrives.
- R2: In level_cfg, bits 7:0 hold the arm level and bits 15:8 hold the fire level. slope_fall = 0 selects a rising trigger and slope_fall = 1 selects a falling trigger.
- R3: With a rising trigger and the detector disarmed, a valid sample strictly below the arm level sets armed at that clock edge. While armed, samples that do not fire leave it armed.
- R4: With a rising trigger and the detector armed, a valid sample strictly above the fire level raises trig_pulse and clears armed at the same edge.
- R5: With a falling trigger, a valid sample strictly above the arm level arms the detector, and once armed a valid sample strictly below the fire level fires it.
- R6: Comparisons are unsigned and strict. A sample equal to a level neither arms nor fires.
- R7: A sample presented with smp_vld low changes neither armed nor triggered and produces no pulse.
- R8: A sample that meets the fire condition while the detector is disarmed produces no pulse.
- R9: trig_pulse is high for exactly one cycle per firing, even if the following samples also meet the fire condition.
- R10: triggered is set by a firing and stays set until a clock edge with clr_trig high and no firing. If a firing and a clear fall on the same edge, triggered stays set.
- R11: When {slope_fall, level_cfg} differs from its value at the previous clock edge (ignoring the first edge after reset), that edge clears armed and neither arms nor fires, whatever the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp | input | 8 | Sample from the filter, unsigned |
| smp_vld | input | 1 | Sample qualifier |
| level_cfg | input | 16 | Fire level in bits 15:8, arm level in bits 7:0 |
| slope_fall | input | 1 | 0 selects a rising trigger, 1 selects a falling trigger |
| clr_trig | input | 1 | Clears the sticky triggered flag |
| trig_pulse | output | 1 | One-cycle trigger event |
| armed | output | 1 | The detector is armed |
| triggered | output | 1 | Sticky flag, set when the trigger fires |

## Verification
The bench targets samples that sit exactly on a level. A design with a non-strict compare would arm or fire on them. It targets samples with the qualifier low, which a design that ignores smp_vld would act on. It also targets a fire-level crossing while disarmed, which a design that skips the arm step would turn into a pulse. It checks that the pulse lasts one cycle during a run of high samples, and that a clear on the same edge as a firing does not win. It changes the configuration while the detector is armed and while a sample would arm or fire. A design that ignores configuration changes would then complete a stale sequence. A randomized phase with occasional configuration changes compares all three outputs against a behavioural model on every clock.

// File: rtl/lvl_trig_pkg.sv
package lvl_trig_pkg;

  typedef enum logic {
    SLOPE_RISE = 1'b0,
    SLOPE_FALL = 1'b1
  } slope_e;

  typedef struct packed {
    logic arm_hit;
    logic fire_hit;
  } hit_t;

endpackage

// File: rtl/lvl_trig_cmp.sv
module lvl_trig_cmp
  import lvl_trig_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] smp,
  input  logic [DW-1:0] arm_lvl,
  input  logic [DW-1:0] fire_lvl,
  input  slope_e        slope,
  output hit_t          hit
);

  logic below_arm, above_arm, below_fire, above_fire;

  always_comb begin
    below_arm  = smp < arm_lvl;
    above_arm  = smp > arm_lvl;
    below_fire = smp < fire_lvl;
    above_fire = smp > fire_lvl;
    if (slope == SLOPE_FALL) begin
      hit.arm_hit  = above_arm;
      hit.fire_hit = below_fire;
    end else begin
      hit.arm_hit  = below_arm;
      hit.fire_hit = above_fire;
    end
  end

endmodule

// File: rtl/lvl_trig_cfgmon.sv
module lvl_trig_cfgmon #(
  parameter int CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg,
  output logic          cfg_chg
);

  logic [CW-1:0] prev_q, prev_d;
  logic          seen_q, seen_d;

  always_comb begin
    cfg_chg = seen_q && (cfg != prev_q);
    prev_d  = cfg;
    seen_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      seen_q <= seen_d;
    end
  end

  // R11: the edge after a change sees the stored copy equal to the input again
  p_cfg_track_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prev_q == $past(cfg)));

endmodule

// File: rtl/lvl_trig_fsm.sv
module lvl_trig_fsm
  import lvl_trig_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld,
  input  logic cfg_chg,
  input  hit_t hit,
  input  logic clr,
  output logic armed_q,
  output logic pulse_q,
  output logic sticky_q
);

  logic armed_d, pulse_d, sticky_d;
  logic arm_en, sticky_en;

  always_comb begin
    armed_d = armed_q;
    pulse_d = 1'b0;
    if (cfg_chg) begin
      armed_d = 1'b0;
    end else if (vld) begin
      if (armed_q && hit.fire_hit) begin
        armed_d = 1'b0;
        pulse_d = 1'b1;
      end else if (!armed_q && hit.arm_hit) begin
        armed_d = 1'b1;
      end
    end
    arm_en    = cfg_chg | vld;
    sticky_en = pulse_d | clr;
    sticky_d  = pulse_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      pulse_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      if (arm_en)    armed_q  <= armed_d;
      if (sticky_en) sticky_q <= sticky_d;
    end
  end

  p_fire_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> $past(armed_q));

  p_fire_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> !armed_q);

  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  p_sticky_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> sticky_q);

  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !clr) |=> sticky_q);

  p_invalid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld && !cfg_chg) |=> ((armed_q == $past(armed_q)) && !pulse_q));

endmodule

// File: rtl/lvl_trig.sv
module lvl_trig
  import lvl_trig_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   smp,
  input  logic            smp_vld,
  input  logic [2*DW-1:0] level_cfg,
  input  logic            slope_fall,
  input  logic            clr_trig,
  output logic            trig_pulse,
  output logic            armed,
  output logic            triggered
);

  localparam int LW = 2 * DW;
  localparam int CW = LW + 1;

  logic [DW-1:0] arm_lvl, fire_lvl;
  slope_e        slope;
  hit_t          hit;
  logic          cfg_chg;

  assign arm_lvl  = level_cfg[DW-1:0];
  assign fire_lvl = level_cfg[LW-1:DW];
  assign slope    = slope_e'(slope_fall);

  lvl_trig_cmp #(.DW(DW)) u_cmp (
    .smp      (smp),
    .arm_lvl  (arm_lvl),
    .fire_lvl (fire_lvl),
    .slope    (slope),
    .hit      (hit)
  );

  lvl_trig_cfgmon #(.CW(CW)) u_cfgmon (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg     ({slope_fall, level_cfg}),
    .cfg_chg (cfg_chg)
  );

  lvl_trig_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld      (smp_vld),
    .cfg_chg  (cfg_chg),
    .hit      (hit),
    .clr      (clr_trig),
    .armed_q  (armed),
    .pulse_q  (trig_pulse),
    .sticky_q (triggered)
  );

  p_cfg_disarm_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (!armed && !trig_pulse));

endmodule

// File: tb/lvl_trig_tb_top.sv
module lvl_trig_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [7:0]  smp;
  logic        smp_vld;
  logic [15:0] level_cfg;
  logic        slope_fall;
  logic        clr_trig;
  logic        trig_pulse, armed, triggered;

  int checks;
  int errors;
  bit done;

  // behavioural reference state
  bit        m_armed, m_pulse, m_sticky, m_seen;
  bit [16:0] m_prev;

  lvl_trig dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp        (smp),
    .smp_vld    (smp_vld),
    .level_cfg  (level_cfg),
    .slope_fall (slope_fall),
    .clr_trig   (clr_trig),
    .trig_pulse (trig_pulse),
    .armed      (armed),
    .triggered  (triggered)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic compare(input string tag);
    checks++;
    if (trig_pulse !== m_pulse || armed !== m_armed || triggered !== m_sticky) begin
      errors++;
      $display("FAIL %s: pulse/armed/triggered actual %0b%0b%0b expected %0b%0b%0b",
               tag, trig_pulse, armed, triggered, m_pulse, m_armed, m_sticky);
    end
  endtask

  task automatic model_edge();
    int  s, al, fl;
    bit  chg, ah, fh, fire;
    s  = smp;
    al = level_cfg[7:0];
    fl = level_cfg[15:8];
    chg = m_seen && ({slope_fall, level_cfg} != m_prev);
    if (slope_fall) begin
      ah = s > al;
      fh = s < fl;
    end else begin
      ah = s < al;
      fh = s > fl;
    end
    fire = 0;
    if (chg) m_armed = 0;
    else if (smp_vld) begin
      if (m_armed && fh) begin
        fire = 1;
        m_armed = 0;
      end else if (!m_armed && ah) m_armed = 1;
    end
    m_pulse = fire;
    if (fire) m_sticky = 1;
    else if (clr_trig) m_sticky = 0;
    m_prev = {slope_fall, level_cfg};
    m_seen = 1;
  endtask

  // called at a falling edge; drives, clocks, compares at the next falling edge
  task automatic step(input logic [7:0] s, input logic v, input logic [15:0] lv,
                      input logic sl, input logic clr, input string tag);
    smp = s; smp_vld = v; level_cfg = lv; slope_fall = sl; clr_trig = clr;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic expect_bits(input logic p, input logic a, input logic t, input string tag);
    checks++;
    if (trig_pulse !== p || armed !== a || triggered !== t) begin
      errors++;
      $display("FAIL %s: pulse/armed/triggered actual %0b%0b%0b expected %0b%0b%0b",
               tag, trig_pulse, armed, triggered, p, a, t);
    end
  endtask

  localparam logic [15:0] RISE_CFG = 16'hC0_40;
  localparam logic [15:0] FALL_CFG = 16'h30_A0;

  initial begin
    checks = 0; errors = 0; done = 0;
    m_armed = 0; m_pulse = 0; m_sticky = 0; m_seen = 0; m_prev = '0;
    rst_n = 1'b0; smp = 8'h00; smp_vld = 1'b0; level_cfg = RISE_CFG;
    slope_fall = 1'b0; clr_trig = 1'b0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    step(8'h80, 1, RISE_CFG, 0, 0, "R1 after reset, mid sample");
    step(8'h40, 1, RISE_CFG, 0, 0, "R6 equal to arm level");
    step(8'h3F, 0, RISE_CFG, 0, 0, "R7 arming sample without valid");
    step(8'h3F, 1, RISE_CFG, 0, 0, "R3 arm below level");
    expect_bits(0, 1, 0, "R2 arm level in bits 7:0");
    step(8'h20, 1, RISE_CFG, 0, 0, "R3 stays armed");
    step(8'hC0, 1, RISE_CFG, 0, 0, "R6 equal to fire level");
    step(8'hFF, 0, RISE_CFG, 0, 0, "R7 firing sample without valid");
    step(8'hC1, 1, RISE_CFG, 0, 0, "R4 fire above level");
    expect_bits(1, 0, 1, "R4 pulse and disarm");
    step(8'hFF, 1, RISE_CFG, 0, 0, "R9 pulse ends");
    step(8'hF0, 1, RISE_CFG, 0, 0, "R8 fire while disarmed");
    expect_bits(0, 0, 1, "R10 sticky held");
    step(8'h80, 0, RISE_CFG, 0, 1, "R10 clear");
    expect_bits(0, 0, 0, "R10 cleared");
    // falling trigger: change edge must not arm
    step(8'hB0, 1, FALL_CFG, 1, 0, "R11 change edge blocks arm");
    step(8'hB0, 1, FALL_CFG, 1, 0, "R5 arm above level");
    expect_bits(0, 1, 0, "R5 armed");
    step(8'hA0, 1, FALL_CFG, 1, 0, "R6 equal arm falling");
    step(8'h30, 1, FALL_CFG, 1, 0, "R6 equal fire falling");
    step(8'h2F, 1, FALL_CFG, 1, 0, "R5 fire below level");
    expect_bits(1, 0, 1, "R5 pulse");
    step(8'h00, 1, FALL_CFG, 1, 1, "R10 clear after fire");
    // arm, then change fire level while a firing sample arrives
    step(8'hB0, 1, FALL_CFG, 1, 0, "R5 rearm");
    step(8'h10, 1, 16'h20_A0, 1, 0, "R11 change blocks fire");
    expect_bits(0, 0, 0, "R11 disarmed, no pulse");
    // fire and clear on the same edge
    step(8'hB0, 1, 16'h20_A0, 1, 0, "R5 arm again");
    step(8'h10, 1, 16'h20_A0, 1, 1, "R10 fire wins over clear");
    expect_bits(1, 0, 1, "R10 set wins");
    // randomized phase
    for (int i = 0; i < 400; i++) begin
      logic [15:0] lv;
      logic        sl;
      lv = (i % 37 == 36) ? 16'($urandom) : ((i / 37) % 2 == 0 ? RISE_CFG : FALL_CFG);
      sl = ((i / 37) % 2 == 1);
      step(8'($urandom), 1'($urandom), lv, sl, ($urandom % 8) == 0, "R2 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule